// File: doc/BRIEF.md
# Two-Digit Decimal Seven-Segment Driver

This block turns a small unsigned binary count into a two-digit decimal readout on a pair of seven-segment displays. A 7-bit value in the range 0 to 99 is split into a tens digit and a units digit, and each digit is encoded into its segment pattern. A value of 100 or more cannot be shown in two decimal places, so both digits show the letter E as an error marker.

The block is purely combinational, with no clock and no reset. It sits between any register holding a count and the segment pins of two display digits. The split uses a shift-and-add-3 binary-to-BCD network that is unrolled at elaboration. A range comparator picks either the decoded digits or the error glyph.

Top module: `dual_digit_seg`

## Requirements
- R1: For inputs 0 to 99, the units bus shows the glyph for (value mod 10).
- R2: For inputs 0 to 99, the tens bus shows the glyph for (value / 10). For inputs below 10 it shows the glyph 0, and no leading zero is blanked.
- R3: For any input from 100 to 127, both buses show the letter E, 7'h79, which lights segments a, d, e, f and g.
- R4: Each segment bus is active high (1 lights a segment), with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. The digit glyphs are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F.
- R5: The change between a numeric display and the error display falls exactly between 99 (shows 99) and 100 (shows EE).
- R6: The outputs follow a change of the input with no clock, within the same time step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 7 | Unsigned binary value to display |
| tens_seg_o | output | 7 | Segment lines of the tens digit, {g,f,e,d,c,b,a} |
| units_seg_o | output | 7 | Segment lines of the units digit, {g,f,e,d,c,b,a} |

## Verification
The block holds no state, so an internal fault can only be a wrong mapping. That fault shows at the segment pins as soon as the offending input code is applied, and each code is checked in the same step it is driven. A bad add-3 correction in the BCD network corrupts only the codes whose intermediate digits reach 5 or more. For that reason every one of the 128 codes is swept, rather than a sample of them. A misplaced range limit shows only at the 99/100 edge, and a swapped segment bit shows only in the glyphs that differ in that bit. Both cases are covered by the exhaustive sweep.

// File: rtl/dual_digit_seg_pkg.sv
package dual_digit_seg_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;   // {g,f,e,d,c,b,a}
  typedef logic [3:0]       bcd_t;

  localparam seg_t SEG_ERR   = 7'h79;
  localparam seg_t SEG_BLANK = 7'h00;
endpackage

// File: rtl/bin_to_bcd.sv
module bin_to_bcd #(
  parameter int DATA_W = 7,
  localparam int NDIG  = (DATA_W * 3 + 9) / 10 + 1
) (
  input  logic [DATA_W-1:0] bin_i,
  output logic [3:0]        tens_o,
  output logic [3:0]        units_o
);
  logic [4*NDIG-1:0] bcd;

  // shift-and-add-3, fully unrolled
  always_comb begin
    bcd = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      for (int d = 0; d < NDIG; d++) begin
        if (bcd[4*d +: 4] >= 4'd5) bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      end
      bcd = {bcd[4*NDIG-2:0], bin_i[i]};
    end
  end

  assign units_o = bcd[3:0];
  assign tens_o  = bcd[7:4];

  always_comb begin
    if (!$isunknown(bin_i) && bin_i < DATA_W'(100)) begin
      assert_units_digit_R1: assert (units_o < 4'd10 &&
        32'(tens_o) * 10 + 32'(units_o) == 32'(bin_i))
        else $error("digit split mismatch for %0d", bin_i);
      assert_tens_digit_R2: assert (tens_o < 4'd10)
        else $error("tens digit out of range for %0d", bin_i);
    end
  end
endmodule

// File: rtl/seg_glyph.sv
module seg_glyph
  import dual_digit_seg_pkg::*;
(
  input  bcd_t digit_i,
  input  logic err_i,
  output seg_t seg_o
);
  seg_t glyph;

  always_comb begin
    unique case (digit_i)
      4'd0: glyph = 7'h3F;
      4'd1: glyph = 7'h06;
      4'd2: glyph = 7'h5B;
      4'd3: glyph = 7'h4F;
      4'd4: glyph = 7'h66;
      4'd5: glyph = 7'h6D;
      4'd6: glyph = 7'h7D;
      4'd7: glyph = 7'h07;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h6F;
      default: glyph = SEG_BLANK;
    endcase
  end

  assign seg_o = err_i ? SEG_ERR : glyph;

  always_comb begin
    if (!$isunknown({digit_i, err_i})) begin
      assert_lit_min_R4: assert ($countones(seg_o) >= 2)
        else $error("glyph lights fewer than two segments");
    end
  end
endmodule

// File: rtl/dual_digit_seg.sv
module dual_digit_seg
  import dual_digit_seg_pkg::*;
#(
  parameter int DATA_W  = 7,
  parameter int MAX_VAL = 99
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [6:0]        tens_seg_o,
  output logic [6:0]        units_seg_o
);
  localparam int NUM_DIG = 2;

  bcd_t tens, units;
  logic err;
  bcd_t digit [NUM_DIG];
  seg_t seg   [NUM_DIG];

  bin_to_bcd #(.DATA_W(DATA_W)) u_split (
    .bin_i  (data_i),
    .tens_o (tens),
    .units_o(units)
  );

  assign err      = 32'(data_i) > MAX_VAL;
  assign digit[0] = units;
  assign digit[1] = tens;

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    seg_glyph u_glyph (
      .digit_i(digit[g]),
      .err_i  (err),
      .seg_o  (seg[g])
    );
  end

  assign units_seg_o = seg[0];
  assign tens_seg_o  = seg[1];

  always_comb begin
    if (!$isunknown(data_i)) begin
      assert_err_pair_R3: assert ((tens_seg_o == SEG_ERR) == (units_seg_o == SEG_ERR))
        else $error("error glyph on only one digit");
      assert_no_err_in_range_R5: assert (err || tens_seg_o != SEG_ERR)
        else $error("error glyph for in-range value");
    end
  end
endmodule

// File: tb/dual_digit_seg_test.sv
module dual_digit_seg_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [6:0] data;
  logic [6:0] tens_seg, units_seg;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_digit_seg uut (
    .data_i     (data),
    .tens_seg_o (tens_seg),
    .units_seg_o(units_seg)
  );

  function automatic logic [6:0] ref_glyph(int d);
    // segments lit per digit, listed as a..g flags
    bit a, b, c, dd, e, f, g;
    a  = !(d == 1 || d == 4);
    b  = !(d == 5 || d == 6);
    c  = (d != 2);
    dd = !(d == 1 || d == 4 || d == 7);
    e  = (d == 0 || d == 2 || d == 6 || d == 8);
    f  = !(d == 1 || d == 2 || d == 3 || d == 7);
    g  = !(d == 0 || d == 1 || d == 7);
    return {g, f, e, dd, c, b, a};
  endfunction

  task automatic check(string req, int v);
    logic [6:0] et, eu;
    if (v > 99) begin et = 7'h79; eu = 7'h79; end
    else begin et = ref_glyph(v / 10); eu = ref_glyph(v % 10); end
    n_run++;
    if (tens_seg !== et || units_seg !== eu) begin
      n_fail++;
      $display("FAIL %s in=%0d got tens=%h units=%h exp tens=%h units=%h",
               req, v, tens_seg, units_seg, et, eu);
    end
  endtask

  task automatic apply(string req, int v);
    @(posedge clk); #1;
    data = 7'(v);
    @(negedge clk);
    check(req, v);
  endtask

  initial begin
    data = 7'd0;
    repeat (3) @(posedge clk);
    #1 check("R2 reset-state zero", 0);
    rst_ni = 1'b1;
    // R4 spot glyphs, R1/R2 every in-range code, R3 every overflow code
    for (int v = 0; v < 128; v++)
      apply(v > 99 ? "R3" : (v < 10 ? "R2" : "R1"), v);
    apply("R5 edge", 99);
    apply("R5 edge", 100);
    apply("R5 edge", 99);
    for (int v = 127; v >= 0; v -= 7) apply("R1 descending", v);
    apply("R4 alt", 85); apply("R4 alt", 42); apply("R3 max", 127);
    // R6: change mid-cycle, no clock edge in between
    @(posedge clk); #1 data = 7'd37;
    #0.5 check("R6", 37);
    data = 7'd104;
    #0.5 check("R6", 104);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_run++; n_fail++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule